// File: doc/BRIEF.md
# Supervision Detector Conditioner with Time-Shared Loop and Ground-Key Sensing

This block conditions the supervision inputs of a group of subscriber line channels. Each channel has a primary detector pin that a line interface can time-share between a loop-detect result and a ground-key result. The block drives a select output, `e1_out`, that tells the line interface which of the two results to place on the pin. On each 1 ms tick the block samples the pin and routes the sample to the holding register of the result that is currently selected. The other result's holding register keeps its last value. Samples taken on the first tick after a select edge are discarded, so the line interface has time to settle.

The loop result goes through a debounce counter that is programmable in milliseconds. The ground-key result goes through a slower filter: a programmable tick divider drives a six-state saturating up/down counter, and the output changes only when the counter reaches one end of its range. When multiplexing is off, the loop holding register follows the pin on every tick, and the second real-time bit of a channel shows a separate raw data input. The debounced bits form a real-time register. Any change of a bit whose interrupt enable is set raises an interrupt that stays asserted until the register is read.

Top module: `supv_cond`

## Requirements
- R1: After reset, `rt_data` is 0, `irq` is 0, and while multiplexing is off `e1_out` equals `e1_pol`.
- R2: With `e1_en`=1 the select phase toggles every HALF_MS ticks, starting in the loop phase. In the loop phase `e1_out` = `e1_pol`; in the ground-key phase `e1_out` = not `e1_pol`. So `e1_pol`=0 gives a high-going ground-key pulse and `e1_pol`=1 a low-going one.
- R3: With `e1_en`=1, a tick sample of `det_a` goes only to the holding register of the current phase, and the other holding register keeps its value. The sample on the first tick after each phase edge is discarded.
- R4: A change of the loop holding register reaches the loop bit only after it has differed from the loop bit on `dbnc_ms`+1 consecutive ticks. `dbnc_ms` covers 0 to 15. A tick on which the two agree restarts the count.
- R5: A divider emits a step every max(`gk_div`,1) ticks. On each step the channel's up/down counter, range 0 to 5, counts up if the ground-key holding register is 1 and down otherwise. The ground-key bit becomes 1 when the counter reaches 5 and becomes 0 when it reaches 0.
- R6: With `e1_en`=0, the loop holding register takes `det_a` on every tick, and real-time bit 2c+1 reports the raw `det_b[c]` instead of the ground-key bit.
- R7: Real-time bit 2c carries channel c's loop bit and bit 2c+1 its second bit. `rt_data` is registered and follows its sources one clock later.
- R8: `irq` is set in the clock after any `rt_data` bit i with `irq_en[i]`=1 changes. Changes of bits with `irq_en[i]`=0 do not set it. Once set, `irq` stays high until a read.
- R9: A one-clock `rd_strobe` clears `irq` in the next clock. If an enabled bit changes in the same clock as the read, `irq` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1k | input | 1 | One-clock pulse every millisecond |
| det_a | input | NCH | Primary detector pin per channel (loop or time-shared loop/ground-key) |
| det_b | input | NCH | Secondary raw data input per channel |
| e1_en | input | 1 | Enables time-shared detector multiplexing |
| e1_pol | input | 1 | Select polarity: 0 = high-going ground-key phase, 1 = low-going |
| dbnc_ms | input | DBW | Loop debounce time in ticks |
| gk_div | input | GKW | Ground-key filter tick divider (0 treated as 1) |
| irq_en | input | 2*NCH | Per-bit interrupt enables for `rt_data` |
| rd_strobe | input | 1 | Real-time register read, clears the interrupt |
| e1_out | output | 1 | Detector select output to the line interfaces |
| rt_data | output | 2*NCH | Real-time supervision bits |
| irq | output | 1 | Sticky interrupt |

## Verification
The hardest case to reach from the ports is a pin that carries different values in the two select phases. The test has to show that each holding register ignores the other phase and that the samples just after an edge are dropped. The bench drives `det_a` from `e1_out` itself, one value in the loop phase and the other in the ground-key phase. It then checks that the loop and ground-key bits settle to opposite values, and repeats the test with the roles swapped. With the largest divider, the same swap also shows the slow rise of the ground-key bit.

// File: rtl/supv_pkg.sv
package supv_pkg;
   localparam int UD_TOP = 5;
   localparam int UD_W   = 3;
   typedef logic [UD_W-1:0] ud_t;
endpackage

// File: rtl/supv_e1_phase.sv
module supv_e1_phase #(
   parameter int HALF_MS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic mux_on,
   input  logic pol,
   output logic gk_phase,
   output logic sample_ok,
   output logic e1_pin
);
   localparam int CW = (HALF_MS > 2) ? $clog2(HALF_MS) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_MS - 1);

   generate
      if (HALF_MS < 2) begin : g_bad_half
         initial $fatal(1, "supv_e1_phase: HALF_MS must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !mux_on) begin
         cnt      <= '0;
         gk_phase <= 1'b0;
      end else if (tick) begin
         if (cnt == LAST) begin
            cnt      <= '0;
            gk_phase <= ~gk_phase;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign sample_ok = mux_on & tick & (cnt != '0);
   assign e1_pin    = mux_on ? (gk_phase ^ pol) : pol;

   assert_phase_off_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      !mux_on |=> !gk_phase);
   assert_phase_tick_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (mux_on && !tick) |=> $stable(gk_phase));
endmodule

// File: rtl/supv_loop_db.sv
module supv_loop_db #(
   parameter int DBW = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick,
   input  logic           take,
   input  logic           din,
   input  logic [DBW-1:0] limit,
   output logic           db
);
   logic           hold;
   logic [DBW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold <= 1'b0;
         db   <= 1'b0;
         cnt  <= '0;
      end else begin
         if (take) hold <= din;
         if (tick) begin
            if (hold == db) begin
               cnt <= '0;
            end else if (cnt == limit) begin
               db  <= hold;
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   assert_db_tick_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(db));
   assert_db_agree_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (hold == db) |=> $stable(db));
endmodule

// File: rtl/supv_gk_filt.sv
module supv_gk_filt
   import supv_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic take,
   input  logic din,
   output logic db
);
   logic hold;
   ud_t  ud;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold <= 1'b0;
         ud   <= '0;
         db   <= 1'b0;
      end else begin
         if (take) hold <= din;
         if (step) begin
            if (hold) begin
               if (ud != ud_t'(UD_TOP)) ud <= ud + 1'b1;
               if (ud == ud_t'(UD_TOP - 1)) db <= 1'b1;
            end else begin
               if (ud != '0) ud <= ud - 1'b1;
               if (ud == ud_t'(1)) db <= 1'b0;
            end
         end
      end
   end

   assert_ud_range_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      ud <= ud_t'(UD_TOP));
   assert_gk_rise_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(db) |-> (ud == ud_t'(UD_TOP)));
   assert_gk_fall_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(db) |-> (ud == '0));
endmodule

// File: rtl/supv_cond.sv
module supv_cond #(
   parameter int NCH     = 4,
   parameter int HALF_MS = 4,
   parameter int DBW     = 4,
   parameter int GKW     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_1k,
   input  logic [NCH-1:0]   det_a,
   input  logic [NCH-1:0]   det_b,
   input  logic             e1_en,
   input  logic             e1_pol,
   input  logic [DBW-1:0]   dbnc_ms,
   input  logic [GKW-1:0]   gk_div,
   input  logic [2*NCH-1:0] irq_en,
   input  logic             rd_strobe,
   output logic             e1_out,
   output logic [2*NCH-1:0] rt_data,
   output logic             irq
);
   localparam int RTW = 2 * NCH;

   generate
      if (NCH < 1 || DBW < 1 || GKW < 1) begin : g_bad_cfg
         initial $fatal(1, "supv_cond: NCH, DBW and GKW must be positive");
      end
   endgenerate

   logic gk_phase, sample_ok, lp_take, gk_take, step;
   logic [GKW-1:0] div_cnt, div_lim;
   logic [NCH-1:0] lp_db, gk_db;
   logic [RTW-1:0] rt_next;

   supv_e1_phase #(.HALF_MS(HALF_MS)) u_phase (
      .clk(clk), .rst_n(rst_n), .tick(tick_1k), .mux_on(e1_en), .pol(e1_pol),
      .gk_phase(gk_phase), .sample_ok(sample_ok), .e1_pin(e1_out));

   assign lp_take = e1_en ? (sample_ok & ~gk_phase) : tick_1k;
   assign gk_take = sample_ok & gk_phase;

   assign div_lim = (gk_div == '0) ? GKW'(1) : gk_div;
   assign step    = tick_1k & (div_cnt >= div_lim - GKW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)       div_cnt <= '0;
      else if (step)    div_cnt <= '0;
      else if (tick_1k) div_cnt <= div_cnt + 1'b1;
   end

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         supv_loop_db #(.DBW(DBW)) u_loop (
            .clk(clk), .rst_n(rst_n), .tick(tick_1k), .take(lp_take),
            .din(det_a[c]), .limit(dbnc_ms), .db(lp_db[c]));
         supv_gk_filt u_gk (
            .clk(clk), .rst_n(rst_n), .step(step), .take(gk_take),
            .din(det_a[c]), .db(gk_db[c]));
         assign rt_next[2*c]   = lp_db[c];
         assign rt_next[2*c+1] = e1_en ? gk_db[c] : det_b[c];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rt_data <= '0;
         irq     <= 1'b0;
      end else begin
         rt_data <= rt_next;
         if (|((rt_next ^ rt_data) & irq_en)) irq <= 1'b1;
         else if (rd_strobe)                  irq <= 1'b0;
      end
   end

   assert_irq_clear_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(rd_strobe));
   assert_irq_sticky_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !rd_strobe) |=> irq);
   assert_demux_excl_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      !(lp_take && gk_take));
endmodule

// File: tb/supv_cond_tb_top.sv
module supv_cond_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NCH        = 4;
   localparam int HALF_MS    = 4;
   localparam int RTW        = 2 * NCH;
   localparam int TICK_DIV   = 4;
   localparam int WD_CYCLES  = 100000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_1k = 1'b0;
   logic [NCH-1:0] det_a = '0, det_b = '0;
   logic e1_en = 1'b0, e1_pol = 1'b0;
   logic [3:0] dbnc_ms = '0, gk_div = 4'd1;
   logic [RTW-1:0] irq_en = '0;
   logic rd_strobe = 1'b0;
   logic e1_out, irq;
   logic [RTW-1:0] rt_data;

   int checks = 0, errors = 0, cyc = 0;
   bit done = 0, follow = 0, follow_inv = 0;

   supv_cond #(.NCH(NCH), .HALF_MS(HALF_MS), .DBW(4), .GKW(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_1k(tick_1k), .det_a(det_a), .det_b(det_b),
      .e1_en(e1_en), .e1_pol(e1_pol), .dbnc_ms(dbnc_ms), .gk_div(gk_div),
      .irq_en(irq_en), .rd_strobe(rd_strobe), .e1_out(e1_out),
      .rt_data(rt_data), .irq(irq));

   always #(CLK_PERIOD/2) clk = ~clk;

   // Reference model state, built from the requirements
   logic [NCH-1:0] m_lph, m_lpdb, m_gkh, m_gkdb;
   logic [3:0] m_lpc [NCH];
   int m_ud [NCH];
   int m_cnt, m_div;
   logic m_ph, m_irq;
   logic [RTW-1:0] m_rt;

   function automatic logic [RTW-1:0] f_rt(input logic [NCH-1:0] lp, gk, b, input logic en);
      logic [RTW-1:0] r;
      for (int c = 0; c < NCH; c++) begin
         r[2*c]   = lp[c];
         r[2*c+1] = en ? gk[c] : b[c];
      end
      return r;
   endfunction

   function automatic logic f_e1(input logic en, ph, pol);
      return en ? (ph ^ pol) : pol;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_lph = '0; m_lpdb = '0; m_gkh = '0; m_gkdb = '0;
         for (int c = 0; c < NCH; c++) begin m_lpc[c] = '0; m_ud[c] = 0; end
         m_cnt = 0; m_div = 0; m_ph = 0; m_irq = 0; m_rt = '0;
      end else begin
         logic [RTW-1:0] nrt;
         logic smp, lpt, gkt, stp;
         int lim;
         nrt = f_rt(m_lpdb, m_gkdb, det_b, e1_en);
         if (|((nrt ^ m_rt) & irq_en)) m_irq = 1'b1;
         else if (rd_strobe)           m_irq = 1'b0;
         m_rt = nrt;
         lim = (gk_div == 0) ? 1 : int'(gk_div);
         stp = tick_1k && (m_div >= lim - 1);
         smp = e1_en && tick_1k && (m_cnt != 0);
         lpt = e1_en ? (smp && !m_ph) : tick_1k;
         gkt = smp && m_ph;
         for (int c = 0; c < NCH; c++) begin
            if (tick_1k) begin
               if (m_lph[c] == m_lpdb[c]) m_lpc[c] = 0;
               else if (m_lpc[c] == dbnc_ms) begin m_lpdb[c] = m_lph[c]; m_lpc[c] = 0; end
               else m_lpc[c] = m_lpc[c] + 1;
            end
            if (stp) begin
               if (m_gkh[c]) m_ud[c] = (m_ud[c] < 5) ? m_ud[c] + 1 : 5;
               else          m_ud[c] = (m_ud[c] > 0) ? m_ud[c] - 1 : 0;
               if (m_ud[c] == 5) m_gkdb[c] = 1'b1;
               if (m_ud[c] == 0) m_gkdb[c] = 1'b0;
            end
            if (lpt) m_lph[c] = det_a[c];
            if (gkt) m_gkh[c] = det_a[c];
         end
         if (!e1_en) begin m_cnt = 0; m_ph = 0; end
         else if (tick_1k) begin
            if (m_cnt == HALF_MS - 1) begin m_cnt = 0; m_ph = ~m_ph; end
            else m_cnt = m_cnt + 1;
         end
         if (stp) m_div = 0; else if (tick_1k) m_div = m_div + 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // Model comparison and tick generation, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R7 model rt_data", 32'(rt_data), 32'(m_rt));
         chk("R8 model irq", 32'(irq), 32'(m_irq));
         chk("R2 model e1_out", 32'(e1_out), 32'(f_e1(e1_en, m_ph, e1_pol)));
      end
      cyc++;
      tick_1k = (cyc % TICK_DIV == 0);
      if (follow) det_a = (((e1_out ^ e1_pol) == follow_inv) ? '1 : '0);
   end

   task automatic wait_ticks(input int n);
      repeat (n) @(posedge clk iff tick_1k);
      @(negedge clk); @(negedge clk);
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      #(CLK_PERIOD * WD_CYCLES);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0C1D));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset rt_data", 32'(rt_data), 0);
      chk("R1 reset irq", 32'(irq), 0);
      chk("R1 reset e1_out", 32'(e1_out), 0);
      e1_pol = 1'b1; @(negedge clk);
      chk("R1 idle e1_out follows pol", 32'(e1_out), 1);
      e1_pol = 1'b0;

      // R6: raw second input with multiplexing off
      det_b = 4'b1010;
      @(negedge clk); @(negedge clk);
      chk("R6 raw det_b on odd bits", 32'(rt_data & 8'hAA), 32'h88);
      chk("R8 masked change keeps irq low", 32'(irq), 0);

      // R4: debounce of 3 needs 4 differing ticks after capture
      dbnc_ms = 4'd3;
      det_a = 4'b0001;
      wait_ticks(4);
      chk("R4 loop bit not yet accepted", 32'(rt_data[0]), 0);
      wait_ticks(1);
      chk("R4 loop bit accepted", 32'(rt_data[0]), 1);
      det_a = 4'b0000; dbnc_ms = 4'd0;
      wait_ticks(2);
      chk("R4 zero debounce falls on first differing tick", 32'(rt_data[0]), 0);

      // R8 / R9
      @(negedge clk); rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
      irq_en = 8'h02;
      det_b[0] = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R8 enabled change sets irq", 32'(irq), 1);
      repeat (5) @(negedge clk);
      chk("R8 irq sticky", 32'(irq), 1);
      rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0; @(negedge clk);
      chk("R9 read clears irq", 32'(irq), 0);
      det_b[0] = 1'b0; rd_strobe = 1'b1;
      @(negedge clk); rd_strobe = 1'b0; @(negedge clk);
      chk("R9 change beats read", 32'(irq), 1);
      rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0; irq_en = '0;
      @(negedge clk);

      // R2: select phase timing and polarity
      e1_en = 1'b1; e1_pol = 1'b0;
      @(negedge clk);
      chk("R2 starts in loop phase", 32'(e1_out), 0);
      wait_ticks(3);
      chk("R2 still loop phase", 32'(e1_out), 0);
      wait_ticks(1);
      chk("R2 high-going ground-key phase", 32'(e1_out), 1);
      e1_pol = 1'b1; @(negedge clk);
      chk("R2 low-going ground-key phase", 32'(e1_out), 0);
      e1_pol = 1'b0;

      // R3: pin differs per phase; each half must keep its own value
      dbnc_ms = 4'd0; gk_div = 4'd1;
      follow_inv = 0; follow = 1;
      wait_ticks(40);
      chk("R3 loop ones, ground-key zeros", 32'(rt_data), 32'h55);

      // R5: swap roles with slowest divider
      gk_div = 4'd15; follow_inv = 1;
      wait_ticks(30);
      chk("R5 ground-key still filtering", 32'(rt_data), 32'h00);
      wait_ticks(100);
      chk("R3 R5 ground-key ones, loop zeros", 32'(rt_data), 32'hAA);
      follow = 0;

      // Constrained random phase checked against the model
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         if ($urandom % 16 == 0)  det_a = 4'($urandom);
         if ($urandom % 24 == 0)  det_b = 4'($urandom);
         if ($urandom % 300 == 0) e1_en = ~e1_en;
         if ($urandom % 400 == 0) e1_pol = ~e1_pol;
         if ($urandom % 150 == 0) dbnc_ms = 4'($urandom % 4);
         if ($urandom % 200 == 0) gk_div = 4'($urandom % 4);
         if ($urandom % 90 == 0)  irq_en = 8'($urandom);
         rd_strobe = ($urandom % 12 == 0);
      end
      rd_strobe = 1'b0;
      @(negedge clk);
      done = 1;
      summary();
      $finish;
   end
endmodule